// File: doc/BRIEF.md
# Cold Boot Reset Sequencer

This block runs the power-on sequence of a processor from a cold start. It watches two supply-good flags, one for the 3.3 V plane and one for the core and PLL supply, and drives three outputs: an active-low processor reset, a power-good output to the processor, and an active-low northbridge reset. Every delay is a whole number of cycles of a free-running reference clock, so the minimum settle and hold times become counter limits.

Power-good rises only after each rail has been good for its own settle window, and the processor reset is held low for that whole time. Once power-good is high, the processor reset is held for a further fixed time so that the PLL can lock. The northbridge reset stays low across the processor reset release and is freed a set number of cycles later. The processor's 4-bit frequency ID is captured at one exact cycle, a set number of cycles after power-good rises, when it is known to be valid. It is presented, together with a done flag, once the sequence ends.

If either rail drops at any time, all outputs return to their reset values on the next cycle and the sequence starts again from idle.

Top module: `cold_boot_seq`

## Requirements
- R1: The processor reset output is low in every cycle in which power-good is low.
- R2: Power-good rises exactly T33_CYC cycles after the first clock edge that samples the 3.3 V flag high, when that flag stays high and the core flag has already settled.
- R3: Power-good never rises before the core flag has been sampled high for CORE_CYC consecutive edges. When that is the later condition, it rises exactly CORE_CYC cycles after the core flag's first high sample.
- R4: The processor reset is released exactly RST_HOLD_CYC cycles after power-good rises.
- R5: The northbridge reset is low while the processor reset is low. It is released exactly NB_LAG_CYC cycles after the processor reset is released, never earlier.
- R6: The frequency ID is sampled on exactly the FID_WAIT_CYC-th clock edge after power-good rises. The values driven before and after that edge have no effect on the captured value.
- R7: Once power-good is high, it stays high while both supply flags stay high.
- R8: If either supply flag is sampled low, then after that edge power-good, both reset outputs, done_o and fid_o are all 0. The sequence then restarts from its beginning when the rails return.
- R9: done_o rises together with the northbridge reset release. fid_o reads 0 while done_o is low, and holds the captured ID unchanged while done_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rail33_ok_i | input | 1 | 3.3 V supply good |
| rail_core_ok_i | input | 1 | Core and PLL supply good |
| fid_i | input | FID_W | Frequency ID from the processor |
| cpu_rst_no | output | 1 | Processor reset, active low |
| pwr_ok_o | output | 1 | Power-good to the processor |
| nb_rst_no | output | 1 | Northbridge reset, active low |
| done_o | output | 1 | Sequence complete |
| fid_o | output | FID_W | Captured frequency ID, valid while done_o is high |

## Verification
The hardest case to reach is a capture of the frequency ID at the exact edge, because an early or late sample looks right whenever the bus is steady. The bench drives the bitwise complement of the intended ID on every cycle except the one edge where the capture must happen. It also sweeps the core flag's arrival against the 3.3 V flag so that each settle window in turn decides the power-good edge. Rail drops are placed inside every phase, each followed by a full restart.

// File: rtl/cbs_pkg.sv
package cbs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PWR  = 2'd1,
    ST_REL  = 2'd2,
    ST_DONE = 2'd3
  } cbs_state_e;
endpackage

// File: rtl/cbs_rail_timer.sv
module cbs_rail_timer #(
  parameter int LIMIT = 500,
  localparam int W = $clog2(LIMIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rail_i,
  output logic ok_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!rail_i)            cnt_q <= '0;
    else if (cnt_q != W'(LIMIT)) cnt_q <= cnt_q + 1'b1;
  end

  assign ok_o = (cnt_q == W'(LIMIT));

  AST_OK_NEEDS_RAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok_o |-> $past(rail_i)); // R3
  AST_DROP_CLEARS_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rail_i |=> !ok_o); // R8
endmodule

// File: rtl/cbs_fid_latch.sv
module cbs_fid_latch #(
  parameter int FID_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             cap_i,
  input  logic             done_i,
  input  logic [FID_W-1:0] fid_i,
  output logic [FID_W-1:0] fid_o
);
  logic [FID_W-1:0] fid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     fid_q <= '0;
    else if (clr_i)  fid_q <= '0;
    else if (cap_i)  fid_q <= fid_i;
  end

  assign fid_o = done_i ? fid_q : '0;

  AST_FID_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && $past(done_i)) |-> $stable(fid_o)); // R9
endmodule

// File: rtl/cbs_seq_fsm.sv
module cbs_seq_fsm
  import cbs_pkg::*;
#(
  parameter int RST_HOLD_CYC = 150000,
  parameter int FID_WAIT_CYC = 10,
  parameter int NB_LAG_CYC   = 16,
  localparam int PH_MAX = (RST_HOLD_CYC > NB_LAG_CYC) ? RST_HOLD_CYC : NB_LAG_CYC,
  localparam int PH_W   = $clog2(PH_MAX + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rails_ok_i,
  input  logic settled_i,
  output logic cap_o,
  output logic pwr_ok_o,
  output logic cpu_rst_no,
  output logic nb_rst_no,
  output logic done_o
);
  cbs_state_e      state_q, state_d;
  logic [PH_W-1:0] ph_q, ph_d;

  always_comb begin
    state_d = state_q;
    ph_d    = ph_q + 1'b1;
    if (!rails_ok_i) begin
      state_d = ST_IDLE;
      ph_d    = '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          ph_d = '0;
          if (settled_i) state_d = ST_PWR;
        end
        ST_PWR: if (ph_q == PH_W'(RST_HOLD_CYC - 1)) begin
          state_d = ST_REL;
          ph_d    = '0;
        end
        ST_REL: if (ph_q == PH_W'(NB_LAG_CYC - 1)) begin
          state_d = ST_DONE;
          ph_d    = '0;
        end
        ST_DONE: ph_d = '0;
        default: begin
          state_d = ST_IDLE;
          ph_d    = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ph_q    <= '0;
    end else begin
      state_q <= state_d;
      ph_q    <= ph_d;
    end
  end

  assign cap_o      = (state_q == ST_PWR) && (ph_q == PH_W'(FID_WAIT_CYC - 1));
  assign pwr_ok_o   = (state_q != ST_IDLE);
  assign cpu_rst_no = (state_q == ST_REL) || (state_q == ST_DONE);
  assign nb_rst_no  = (state_q == ST_DONE);
  assign done_o     = (state_q == ST_DONE);

  AST_PWR_MONO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_ok_o && rails_ok_i) |=> pwr_ok_o); // R7
  AST_PWR_AFTER_SETTLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwr_ok_o) |-> $past(settled_i)); // R2
  AST_CPU_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwr_ok_o) |-> !cpu_rst_no); // R1
  AST_NB_AFTER_CPU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nb_rst_no) |-> $past(cpu_rst_no)); // R5
  AST_DROP_RESETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rails_ok_i |=> (!pwr_ok_o && !cpu_rst_no && !nb_rst_no && !done_o)); // R8
endmodule

// File: rtl/cold_boot_seq.sv
module cold_boot_seq #(
  parameter int T33_CYC      = 300000,
  parameter int CORE_CYC     = 500,
  parameter int RST_HOLD_CYC = 150000,
  parameter int FID_WAIT_CYC = 10,
  parameter int NB_LAG_CYC   = 16,
  parameter int FID_W        = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rail33_ok_i,
  input  logic             rail_core_ok_i,
  input  logic [FID_W-1:0] fid_i,
  output logic             cpu_rst_no,
  output logic             pwr_ok_o,
  output logic             nb_rst_no,
  output logic             done_o,
  output logic [FID_W-1:0] fid_o
);
  localparam int NRAIL = 2;

  logic [NRAIL-1:0] rail_w, ok_w;
  logic             cap_w, rails_ok_w;

  assign rail_w     = {rail_core_ok_i, rail33_ok_i};
  assign rails_ok_w = &rail_w;

  for (genvar g = 0; g < NRAIL; g++) begin : g_rail
    cbs_rail_timer #(.LIMIT(g == 0 ? T33_CYC : CORE_CYC)) u_timer (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .rail_i(rail_w[g]),
      .ok_o  (ok_w[g])
    );
  end

  cbs_seq_fsm #(
    .RST_HOLD_CYC(RST_HOLD_CYC),
    .FID_WAIT_CYC(FID_WAIT_CYC),
    .NB_LAG_CYC  (NB_LAG_CYC)
  ) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rails_ok_i(rails_ok_w),
    .settled_i (&ok_w),
    .cap_o     (cap_w),
    .pwr_ok_o  (pwr_ok_o),
    .cpu_rst_no(cpu_rst_no),
    .nb_rst_no (nb_rst_no),
    .done_o    (done_o)
  );

  cbs_fid_latch #(.FID_W(FID_W)) u_fid (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (!rails_ok_w),
    .cap_i (cap_w),
    .done_i(done_o),
    .fid_i (fid_i),
    .fid_o (fid_o)
  );

  initial begin
    if (FID_WAIT_CYC < 1 || FID_WAIT_CYC > RST_HOLD_CYC || NB_LAG_CYC < 1)
      $error("cold_boot_seq: bad timing parameters");
  end
endmodule

// File: tb/cold_boot_seq_test.sv
`timescale 1ns/1ps
module cold_boot_seq_test;
  localparam int T33 = 12;
  localparam int TC  = 5;
  localparam int TR  = 20;
  localparam int FW  = 3;
  localparam int TN  = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       r33 = 1'b0, rc = 1'b0;
  logic [3:0] fid = 4'h0;
  logic       cpu_rst_n, pwr_ok, nb_rst_n, done;
  logic [3:0] fid_out;
  int         n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  cold_boot_seq #(
    .T33_CYC(T33), .CORE_CYC(TC), .RST_HOLD_CYC(TR),
    .FID_WAIT_CYC(FW), .NB_LAG_CYC(TN), .FID_W(4)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .rail33_ok_i(r33), .rail_core_ok_i(rc),
    .fid_i(fid), .cpu_rst_no(cpu_rst_n), .pwr_ok_o(pwr_ok),
    .nb_rst_no(nb_rst_n), .done_o(done), .fid_o(fid_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // a, b: first edge sampling 3.3 V / core high; drop_at: edge where a rail goes low (0 = none)
  task automatic run_seq(input int a, input int b, input logic [3:0] v,
                         input int drop_at, input int which);
    int p, rel, dn, n_end;
    bit dropped, e_pwr, e_cpu, e_done;
    p     = (a + T33 > b + TC) ? a + T33 : b + TC;
    rel   = p + TR;
    dn    = rel + TN;
    n_end = (drop_at > 0) ? drop_at + 2 : dn + 3;
    for (int i = 1; i <= n_end; i++) begin
      dropped = (drop_at > 0) && (i >= drop_at);
      r33 = (i >= a) && !(dropped && which == 0);
      rc  = (i >= b) && !(dropped && which == 1);
      fid = (i == p + FW) ? v : ~v;
      @(posedge clk);
      @(negedge clk);
      e_pwr  = !dropped && (i >= p);
      e_cpu  = !dropped && (i >= rel);
      e_done = !dropped && (i >= dn);
      if (dropped) begin
        chk("R8 pwr_ok", pwr_ok, 0);
        chk("R8 cpu_rst", cpu_rst_n, 0);
        chk("R8 nb_rst", nb_rst_n, 0);
        chk("R8 fid_o", fid_out, 0);
      end else begin
        if (i < p) chk((b + TC > a + T33) ? "R3 pwr_ok" : "R2 pwr_ok", pwr_ok, 0);
        else if (i == p) chk((b + TC > a + T33) ? "R3 pwr_ok rise" : "R2 pwr_ok rise", pwr_ok, 1);
        else chk("R7 pwr_ok", pwr_ok, 1);
        chk(e_pwr ? "R4 cpu_rst" : "R1 cpu_rst", cpu_rst_n, int'(e_cpu));
        chk("R5 nb_rst", nb_rst_n, int'(e_done));
        chk("R9 done", done, int'(e_done));
        chk(e_done ? "R6 fid_o" : "R9 fid_o", fid_out, e_done ? int'(v) : 0);
      end
    end
    r33 = 1'b0;
    rc  = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset cpu_rst", cpu_rst_n, 0);
    chk("R8 reset pwr_ok", pwr_ok, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R5 reset nb_rst", nb_rst_n, 0);
    chk("R9 reset done", done, 0);
    // sweep core arrival against 3.3 V arrival
    for (int d = 0; d <= T33 - TC + 4; d++)
      run_seq(1, 1 + d, 4'(d) ^ 4'hA, 0, 0);
    run_seq(6, 1, 4'h5, 0, 0);
    // drops in every phase, each followed by a clean restart
    for (int w = 0; w < 2; w++) begin
      run_seq(1, 1, 4'h3, T33 - 2, w);
      run_seq(1, 1, 4'hC, 1 + T33 + 1, w);
      run_seq(1, 1, 4'h9, 1 + T33 + FW + 1, w);
      run_seq(1, 1, 4'h6, 1 + T33 + TR + 1, w);
      run_seq(1, 1, 4'hE, 1 + T33 + TR + TN + 2, w);
      run_seq(1, 1, 4'h1, 0, 0);
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule